// File: doc/BRIEF.md
# Multi-Source Reset Controller with Sticky Cause Register

This block merges seven reset requests into one active-high system reset and records which requests have fired. The requests are power-on, brown-out, the external master-clear pin, a software reset command, watchdog expiry, trap conflict, and illegal-opcode or uninitialized-register use. The master-clear pin is active low and asynchronous. It passes through a two-flop synchronizer and a low-level glitch filter, and only then can it request a reset. The other requests are digital levels that come from detectors and CPU logic outside this block.

Any active request raises `sys_rst` at once. After the last request drops, a state machine with three states keeps `sys_rst` high for a fixed number of clock cycles and then releases it on a clock edge:

- `ST_HOLD`: a request is present.
- `ST_DRAIN`: counting out the stretch.
- `ST_RUN`: normal operation.

The transitions are:

- `HOLD->DRAIN` when no request remains.
- `DRAIN->HOLD` when a request returns.
- `DRAIN->RUN` when the stretch count completes.
- `RUN->HOLD` on any request.

Power-on forces the machine into `ST_HOLD` asynchronously.

Software reads and writes a 16-bit cause register through a simple port. Bits 0 to 6 are sticky cause flags. Bits 7 to 15 are plain storage for watchdog and power-saving settings. Power-on loads the whole register with 0x0001. Any other reset only sets the flag for its own cause and leaves every other bit alone, so older causes stay visible until software clears them.

Top module: `rstc_top`

## Requirements
- R1: Any of brn_req, swr_req, wdog_req, trap_req, illop_req or por_req, alone or together, drives sys_rst high in the same cycle without waiting for a clock edge.
- R2: Each reset event sets its own cause bit: bit 0 power-on, bit 1 brown-out, bit 2 master-clear pin, bit 3 software command, bit 4 watchdog, bit 5 trap conflict, bit 6 illegal opcode or uninitialized register.
- R3: A reset event other than power-on leaves every other cause-register bit at its previous value.
- R4: While por_req is high, reg_rdata reads 0x0001. Power-on clears every other bit, including the plain storage bits 7 to 15.
- R5: When reg_we is high during a cycle with sys_rst low, reg_rdata equals that cycle's reg_wdata from the next clock edge onward.
- R6: A software write, including one that sets cause bits 1 to 6, never asserts sys_rst.
- R7: A write issued while sys_rst is high has no effect on the cause register.
- R8: The master-clear pin is accepted only after its synchronized level has been low on FILT_LEN consecutive clock edges (default 4). A shorter low pulse neither asserts sys_rst nor sets bit 2.
- R9: When all requests are low, sys_rst stays high for exactly STRETCH_LEN samples taken at the falling clock edges that follow the release (default 8), and is low at the next sample.
- R10: Bits 7 to 15 keep whatever software last wrote to them. No reset other than power-on changes them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_req | input | 1 | Power-on request, active high, asynchronous; also the block's own reset |
| brn_req | input | 1 | Brown-out request, active high |
| mclr_pin_n | input | 1 | External master-clear pin, active low, asynchronous |
| swr_req | input | 1 | Software reset command, active high |
| wdog_req | input | 1 | Watchdog expiry request, active high |
| trap_req | input | 1 | Trap conflict request, active high |
| illop_req | input | 1 | Illegal opcode or uninitialized register request, active high |
| reg_we | input | 1 | Cause register write enable |
| reg_wdata | input | 16 | Cause register write data |
| sys_rst | output | 1 | System reset, active high |
| reg_rdata | output | 16 | Current cause register value |

## Verification
The assertions assume that a por_req pulse spans at least one rising clock edge. They also assume that the other requests are levels that change between edges. The master-clear pin is the only input allowed to move freely, and it is synchronized. The stretch check assumes that all requests stay low once released, because its window counter restarts on any new request. The bench changes every input at the falling clock edge, holds each request for whole cycles, and issues writes in cycles where the reset state is known. The design therefore never sees a write racing a request edge.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

    localparam int unsigned REG_W = 16;
    localparam int unsigned N_SRC = 7;

    localparam int unsigned B_PON   = 0;
    localparam int unsigned B_BRN   = 1;
    localparam int unsigned B_PIN   = 2;
    localparam int unsigned B_SWR   = 3;
    localparam int unsigned B_WDOG  = 4;
    localparam int unsigned B_TRAP  = 5;
    localparam int unsigned B_ILLOP = 6;

    localparam logic [REG_W-1:0] PON_VALUE = REG_W'(1) << B_PON;

    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_DRAIN = 2'd1,
        ST_RUN   = 2'd2
    } rst_state_e;

endpackage

// File: rtl/rstc_pin_filter.sv
module rstc_pin_filter #(
    parameter int unsigned FILT_LEN = 4
) (
    input  logic clk,
    input  logic arst,
    input  logic pin_n,
    output logic pin_hit
);
    localparam int unsigned CNT_W = $clog2(FILT_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(FILT_LEN);

    logic [1:0]       sync_q;
    logic [CNT_W-1:0] low_cnt;

    // two-flop synchronizer, idles high (pin released)
    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            sync_q <= 2'b11;
        end else begin
            sync_q <= {sync_q[0], pin_n};
        end
    end

    // consecutive-low counter, saturating at the acceptance length
    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            low_cnt <= '0;
        end else if (sync_q[1]) begin
            low_cnt <= '0;
        end else if (low_cnt != CNT_TOP) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    assign pin_hit = (low_cnt == CNT_TOP);

endmodule

// File: rtl/rstc_stretch_fsm.sv
module rstc_stretch_fsm
    import rstc_pkg::*;
#(
    parameter int unsigned STRETCH_LEN = 8
) (
    input  logic clk,
    input  logic arst,
    input  logic req_any,
    output logic busy
);
    localparam int unsigned CNT_W = $clog2(STRETCH_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STRETCH_LEN - 1);

    rst_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;

    // state register and drain counter
    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            state_q <= ST_HOLD;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                ST_HOLD: begin
                    cnt_q <= '0;
                    if (!req_any) begin
                        state_q <= ST_DRAIN;   // HOLD->DRAIN
                    end
                end
                ST_DRAIN: begin
                    if (req_any) begin
                        state_q <= ST_HOLD;    // DRAIN->HOLD
                        cnt_q   <= '0;
                    end else if (cnt_q == CNT_LAST) begin
                        state_q <= ST_RUN;     // DRAIN->RUN
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_RUN: begin
                    cnt_q <= '0;
                    if (req_any) begin
                        state_q <= ST_HOLD;    // RUN->HOLD
                    end
                end
                default: begin
                    state_q <= ST_HOLD;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    // output decode
    always_comb begin
        unique case (state_q)
            ST_HOLD:  busy = 1'b1;
            ST_DRAIN: busy = 1'b1;
            ST_RUN:   busy = 1'b0;
            default:  busy = 1'b1;
        endcase
    end

endmodule

// File: rtl/rstc_cause_reg.sv
module rstc_cause_reg
    import rstc_pkg::*;
(
    input  logic             clk,
    input  logic             arst,
    input  logic [N_SRC-1:0] hw_set,
    input  logic             we_ok,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] cause
);
    logic [REG_W-1:0] nxt;

    for (genvar b = 0; b < REG_W; b++) begin : g_bit
        if (b < N_SRC) begin : g_flag
            // sticky flag: hardware set has priority over a software value
            assign nxt[b] = hw_set[b] | (we_ok ? wdata[b] : cause[b]);
        end else begin : g_plain
            assign nxt[b] = we_ok ? wdata[b] : cause[b];
        end
    end

    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            cause <= PON_VALUE;
        end else begin
            cause <= nxt;
        end
    end

endmodule

// File: rtl/rstc_top.sv
module rstc_top
    import rstc_pkg::*;
#(
    parameter int unsigned FILT_LEN    = 4,
    parameter int unsigned STRETCH_LEN = 8
) (
    input  logic        clk,
    input  logic        por_req,
    input  logic        brn_req,
    input  logic        mclr_pin_n,
    input  logic        swr_req,
    input  logic        wdog_req,
    input  logic        trap_req,
    input  logic        illop_req,
    input  logic        reg_we,
    input  logic [15:0] reg_wdata,
    output logic        sys_rst,
    output logic [15:0] reg_rdata
);
    logic             pin_hit;
    logic             busy;
    logic             req_any;
    logic             we_ok;
    logic [N_SRC-1:0] hw_set;

    rstc_pin_filter #(.FILT_LEN(FILT_LEN)) u_filt (
        .clk     (clk),
        .arst    (por_req),
        .pin_n   (mclr_pin_n),
        .pin_hit (pin_hit)
    );

    always_comb begin
        hw_set          = '0;
        hw_set[B_BRN]   = brn_req;
        hw_set[B_PIN]   = pin_hit;
        hw_set[B_SWR]   = swr_req;
        hw_set[B_WDOG]  = wdog_req;
        hw_set[B_TRAP]  = trap_req;
        hw_set[B_ILLOP] = illop_req;
    end

    assign req_any = |hw_set;

    rstc_stretch_fsm #(.STRETCH_LEN(STRETCH_LEN)) u_fsm (
        .clk     (clk),
        .arst    (por_req),
        .req_any (req_any),
        .busy    (busy)
    );

    assign sys_rst = por_req | req_any | busy;
    assign we_ok   = reg_we & ~sys_rst;

    rstc_cause_reg u_cause (
        .clk    (clk),
        .arst   (por_req),
        .hw_set (hw_set),
        .we_ok  (we_ok),
        .wdata  (reg_wdata),
        .cause  (reg_rdata)
    );

endmodule

// File: rtl/rstc_checker.sv
module rstc_checker #(
    parameter int unsigned STRETCH_LEN = 8
) (
    input logic        clk,
    input logic        por_req,
    input logic        brn_req,
    input logic        swr_req,
    input logic        wdog_req,
    input logic        trap_req,
    input logic        illop_req,
    input logic        pin_hit,
    input logic        reg_we,
    input logic [15:0] reg_wdata,
    input logic        sys_rst,
    input logic [15:0] reg_rdata
);
    localparam int unsigned QW = $clog2(STRETCH_LEN + 3) + 1;
    localparam logic [QW-1:0] QMAX = {QW{1'b1}};

    logic        hw_any;
    logic [15:0] hw_bits;
    logic [QW-1:0] quiet_q;

    assign hw_any  = brn_req | swr_req | wdog_req | trap_req | illop_req;
    assign hw_bits = {9'b0, illop_req, trap_req, wdog_req, swr_req, pin_hit, brn_req, 1'b0};

    always_ff @(posedge clk or posedge por_req) begin
        if (por_req) begin
            quiet_q <= '0;
        end else if (hw_any || pin_hit) begin
            quiet_q <= '0;
        end else if (sys_rst && quiet_q != QMAX) begin
            quiet_q <= quiet_q + 1'b1;
        end
    end

    AST_SRC_RST: assert property (@(posedge clk) (hw_any || por_req) |-> sys_rst); // R1
    AST_CAUSE_SET: assert property (@(posedge clk) disable iff (por_req)
        hw_any |=> ((reg_rdata & $past(hw_bits)) == $past(hw_bits))); // R2
    AST_BITS_KEEP: assert property (@(posedge clk) disable iff (por_req)
        sys_rst |=> ((reg_rdata & $past(reg_rdata)) == $past(reg_rdata))); // R3
    AST_POR_VALUE: assert property (@(posedge clk) por_req |-> (reg_rdata == 16'h0001)); // R4
    AST_WR_LOAD: assert property (@(posedge clk) disable iff (por_req)
        (!sys_rst && reg_we) |=> (reg_rdata == $past(reg_wdata))); // R5
    AST_WR_NO_RST: assert property (@(posedge clk) disable iff (por_req)
        ($past(!sys_rst && reg_we) && !hw_any && !pin_hit) |-> !sys_rst); // R6
    AST_PIN_RST: assert property (@(posedge clk) pin_hit |-> sys_rst); // R8
    AST_STRETCH: assert property (@(posedge clk) disable iff (por_req)
        $fell(sys_rst) |-> (quiet_q == QW'(STRETCH_LEN + 1))); // R9

endmodule

bind rstc_top rstc_checker #(.STRETCH_LEN(STRETCH_LEN)) u_chk (
    .clk       (clk),
    .por_req   (por_req),
    .brn_req   (brn_req),
    .swr_req   (swr_req),
    .wdog_req  (wdog_req),
    .trap_req  (trap_req),
    .illop_req (illop_req),
    .pin_hit   (pin_hit),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .sys_rst   (sys_rst),
    .reg_rdata (reg_rdata)
);

// File: tb/rstc_top_tb_top.sv
module rstc_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int FILT       = 4;
    localparam int STRETCH    = 8;
    localparam int NV         = 7;

    // mask bits: 0 brown-out, 1 software, 2 watchdog, 3 trap, 4 illegal op, 5 pin
    localparam logic [5:0]  V_MASK [NV] = '{6'b000001, 6'b000010, 6'b000100, 6'b011000,
                                           6'b100000, 6'b100011, 6'b011111};
    localparam int          V_CYC  [NV] = '{3, 1, 2, 2, 6, 6, 1};
    localparam logic [15:0] V_PRE  [NV] = '{16'h0000, 16'h0080, 16'h0001, 16'h0000,
                                           16'h0200, 16'h0000, 16'hF000};

    logic        clk = 1'b0;
    logic        por_req = 1'b0;
    logic        brn_req = 1'b0;
    logic        mclr_pin_n = 1'b1;
    logic        swr_req = 1'b0;
    logic        wdog_req = 1'b0;
    logic        trap_req = 1'b0;
    logic        illop_req = 1'b0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic        sys_rst;
    logic [15:0] reg_rdata;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rstc_top #(.FILT_LEN(FILT), .STRETCH_LEN(STRETCH)) dut_i (
        .clk(clk), .por_req(por_req), .brn_req(brn_req), .mclr_pin_n(mclr_pin_n),
        .swr_req(swr_req), .wdog_req(wdog_req), .trap_req(trap_req), .illop_req(illop_req),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .sys_rst(sys_rst), .reg_rdata(reg_rdata)
    );

    task automatic chk16(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk1(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mask_bits(input logic [5:0] m);
        logic [15:0] r = '0;
        r[1] = m[0]; r[3] = m[1]; r[4] = m[2]; r[5] = m[3]; r[6] = m[4]; r[2] = m[5];
        return r;
    endfunction

    task automatic drive(input logic [5:0] m);
        brn_req    = m[0];
        swr_req    = m[1];
        wdog_req   = m[2];
        trap_req   = m[3];
        illop_req  = m[4];
        mclr_pin_n = ~m[5];
    endtask

    task automatic sw_write(input logic [15:0] v);
        @(negedge clk);
        reg_we = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 100 && sys_rst; i++) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int n;
        logic [15:0] prev;
        #2 por_req = 1'b1;
        repeat (3) @(negedge clk);
        chk1("R1 por asserts sys_rst", sys_rst, 1'b1);
        chk16("R4 cause during por", reg_rdata, 16'h0001);
        por_req = 1'b0;
        n = 0;
        @(negedge clk);
        while (sys_rst && n < 50) begin n++; @(negedge clk); end
        chk16("R9 stretch after por", 16'(n), 16'(STRETCH));

        // vector table
        for (int v = 0; v < NV; v++) begin
            sw_write(V_PRE[v]);
            chk16("R5 preload readback", reg_rdata, V_PRE[v]);
            @(negedge clk);
            drive(V_MASK[v]);
            repeat (V_CYC[v]) @(negedge clk);
            chk1("R1 sys_rst during request", sys_rst, 1'b1);
            drive(6'b0);
            repeat (4) @(negedge clk);
            wait_idle();
            chk16("R2 R3 R10 cause after request", reg_rdata, V_PRE[v] | mask_bits(V_MASK[v]));
        end

        // asynchronous assertion mid-cycle
        @(negedge clk);
        #1 trap_req = 1'b1;
        #1 chk1("R1 async assert", sys_rst, 1'b1);
        @(negedge clk);
        trap_req = 1'b0;
        wait_idle();

        // stretch after a brown-out
        sw_write(16'h0000);
        @(negedge clk);
        brn_req = 1'b1;
        repeat (2) @(negedge clk);
        brn_req = 1'b0;
        n = 0;
        @(negedge clk);
        while (sys_rst && n < 50) begin n++; @(negedge clk); end
        chk16("R9 stretch after brown-out", 16'(n), 16'(STRETCH));

        // write never resets
        sw_write(16'h007E);
        chk1("R6 write of flags no reset", sys_rst, 1'b0);
        repeat (5) @(negedge clk);
        chk1("R6 still out of reset", sys_rst, 1'b0);
        chk16("R5 flags written", reg_rdata, 16'h007E);
        sw_write(16'h0000);
        chk16("R5 flags cleared by software", reg_rdata, 16'h0000);

        // write ignored while in reset
        sw_write(16'h0400);
        prev = reg_rdata;
        @(negedge clk);
        wdog_req = 1'b1;
        @(negedge clk);
        reg_we = 1'b1;
        reg_wdata = 16'h5555;
        @(negedge clk);
        reg_we = 1'b0;
        wdog_req = 1'b0;
        @(negedge clk);
        wait_idle();
        chk16("R7 write during reset ignored", reg_rdata, prev | 16'h0010);

        // short pin pulse ignored
        sw_write(16'h0000);
        @(negedge clk);
        mclr_pin_n = 1'b0;
        repeat (FILT - 1) @(negedge clk);
        mclr_pin_n = 1'b1;
        n = 0;
        for (int i = 0; i < 10; i++) begin
            if (sys_rst) n++;
            @(negedge clk);
        end
        chk16("R8 short pin pulse no reset", 16'(n), 16'h0000);
        chk16("R8 short pin pulse no flag", reg_rdata, 16'h0000);

        // pin pulse of exactly the acceptance length
        @(negedge clk);
        mclr_pin_n = 1'b0;
        repeat (FILT) @(negedge clk);
        mclr_pin_n = 1'b1;
        n = 0;
        for (int i = 0; i < 6; i++) begin
            if (sys_rst) n++;
            @(negedge clk);
        end
        chk1("R8 boundary pin pulse resets", n > 0, 1'b1);
        wait_idle();
        chk16("R8 boundary pin pulse flag", reg_rdata, 16'h0004);

        // power-on clears everything but bit 0
        sw_write(16'hABCD);
        chk16("R10 plain bits written", reg_rdata, 16'hABCD);
        @(negedge clk);
        por_req = 1'b1;
        @(negedge clk);
        chk16("R4 por clears plain and flag bits", reg_rdata, 16'h0001);
        por_req = 1'b0;
        wait_idle();
        chk16("R4 after por release", reg_rdata, 16'h0001);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule